// File: doc/BRIEF.md
# Tear-Free Write-Pointer Snapshot Reader

This block keeps the write pointer of a circular buffer and lets a host read it through three read-only byte registers. The pointer moves up by one on each write strobe. When a strobe arrives while the pointer sits on the programmed end address, the pointer goes back to the start address and a sticky wrap flag is set. The value the host sees is 20 bits wide. The low 19 bits are the address and the top bit is the wrap flag.

Software reads the pointer byte by byte, and the pointer can move between two reads. To stop a read from being torn, the host reads the low byte first. The same clock edge that returns the low byte also copies the upper bytes of the live value into holding registers. Later reads of the middle and top registers return those held copies, so all the bytes read in one sequence belong to one snapshot. A buffer reset reloads the start address and clears the flag. A separate host clear input clears only the flag.

Top module: `ptr_snap_reader`

## Requirements
- R1: After `rst`, the pointer is 0, the wrap flag is 0 and the holding registers are 0. `rd_data` is 0, and every register select reads back 0.
- R2: A read with `rd_en` high and `rd_sel` set places the selected byte on `rd_data` at the next rising edge. While `rd_en` is low, `rd_data` keeps its value.
- R3: Each `wr_stb` cycle with the pointer not equal to `end_addr` raises the pointer by one.
- R4: A `wr_stb` cycle with the pointer equal to `end_addr` loads `start_addr` into the pointer and sets the wrap flag. The wrap flag is bit 19 of the value, which is bit 3 of select code 2.
- R5: The wrap flag stays set until `buf_rst` or `wrap_clr`. If a wrap and `wrap_clr` occur in the same cycle, the flag ends up set.
- R6: `buf_rst` loads `start_addr` and clears the wrap flag. It takes priority over `wr_stb`.
- R7: Select code 0 returns live bits [7:0]. At the same edge it copies live bits [19:8] into the holding registers.
- R8: Select code 1 returns the held bits [15:8]. Select code 2 returns the held bits [19:16] in bits [3:0], with bits [7:4] reading 0. The held bytes do not change until the next code-0 read, however far the pointer moves.
- R9: Select code 3 is reserved and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_rst | input | 1 | Buffer reset: reload start address, clear wrap flag |
| wr_stb | input | 1 | Write strobe, advances the pointer |
| wrap_clr | input | 1 | Host clear of the wrap flag |
| start_addr | input | 19 | Buffer start address |
| end_addr | input | 19 | Buffer end address |
| rd_en | input | 1 | Host byte read strobe |
| rd_sel | input | 2 | Register select: 0 low, 1 middle, 2 top, 3 reserved |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |

## Verification
The main corner case is a pointer that crosses a byte boundary between the low-byte read and the upper-byte reads. A design that drives the upper registers from the live pointer would return a middle and top byte that do not match the low byte. The wrap cases check the following:
- the reload lands exactly on the start address, not one past it;
- the flag survives further strobes;
- the flag is not lost when a clear coincides with a new wrap;
- a buffer reset overrides a simultaneous strobe.

Reads of the top register and of the reserved code show whether the unused bits leak data.

// File: rtl/ptr_snap_pkg.sv
package ptr_snap_pkg;

    localparam int BYTE_W     = 8;
    localparam int DEF_ADDR_W = 19;

    typedef enum logic [1:0] {
        REG_LO  = 2'd0,
        REG_MID = 2'd1,
        REG_HI  = 2'd2,
        REG_RSV = 2'd3
    } rd_reg_e;

    function automatic int n_bytes(input int bits);
        return (bits + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/ptr_snap_wptr.sv
module ptr_snap_wptr #(
    parameter int ADDR_W = ptr_snap_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_rst,
    input  logic              wr_stb,
    input  logic              wrap_clr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);

    logic at_end;
    assign at_end = (addr == end_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            wrap <= 1'b0;
        end else if (buf_rst) begin
            addr <= start_addr;
            wrap <= 1'b0;
        end else begin
            if (wr_stb) begin
                addr <= at_end ? start_addr : addr + ADDR_W'(1);
            end
            if (wr_stb && at_end) begin
                wrap <= 1'b1;
            end else if (wrap_clr) begin
                wrap <= 1'b0;
            end
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!buf_rst && wr_stb && addr != end_addr) |=> addr == $past(addr) + ADDR_W'(1)); // R3
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!buf_rst && wr_stb && addr == end_addr) |=> (addr == $past(start_addr) && wrap)); // R4
    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wrap && !buf_rst && !wrap_clr) |=> wrap); // R5
    AST_BUF_RST: assert property (@(posedge clk) disable iff (rst)
        buf_rst |=> (addr == $past(start_addr) && !wrap)); // R6

endmodule

// File: rtl/ptr_snap_capture.sv
module ptr_snap_capture #(
    parameter int PAD_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [PAD_W-1:0] live,
    output logic [PAD_W-1:8] held
);

    localparam int NB = PAD_W / ptr_snap_pkg::BYTE_W;

    for (genvar b = 1; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                held[b*8 +: 8] <= '0;
            end else if (cap_en) begin
                held[b*8 +: 8] <= live[b*8 +: 8];
            end
        end
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> held == $past(live[PAD_W-1:8])); // R7
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(held)); // R8

endmodule

// File: rtl/ptr_snap_rdmux.sv
module ptr_snap_rdmux #(
    parameter int PAD_W = 24,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [7:0]       live_lo,
    input  logic [PAD_W-1:8] held,
    output logic [7:0]       rd_data
);

    localparam int NB = PAD_W / ptr_snap_pkg::BYTE_W;

    logic [7:0] nxt;

    always_comb begin
        nxt = '0;
        if (rd_sel == SEL_W'(ptr_snap_pkg::REG_LO)) begin
            nxt = live_lo;
        end
        for (int b = 1; b < NB; b++) begin
            if (rd_sel == SEL_W'(b)) begin
                nxt = held[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= nxt;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R2
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(rd_sel) >= NB) |=> rd_data == 8'h00); // R9

endmodule

// File: rtl/ptr_snap_reader.sv
module ptr_snap_reader #(
    parameter int ADDR_W = ptr_snap_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_rst,
    input  logic              wr_stb,
    input  logic              wrap_clr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data
);

    localparam int VAL_W  = ADDR_W + 1;
    localparam int NB     = ptr_snap_pkg::n_bytes(VAL_W);
    localparam int PAD_W  = NB * ptr_snap_pkg::BYTE_W;
    localparam int TOP_W  = VAL_W - 8 * (NB - 1);
    localparam logic [7:0] HI_MASK = 8'(16'hFF << TOP_W);

    logic [ADDR_W-1:0] addr;
    logic              wrap;
    logic [PAD_W-1:0]  live;
    logic [PAD_W-1:8]  held;
    logic              cap_en;

    always_comb begin
        live = '0;
        live[VAL_W-1:0] = {wrap, addr};
    end

    assign cap_en = rd_en && (rd_sel == ptr_snap_pkg::REG_LO);

    ptr_snap_wptr #(.ADDR_W(ADDR_W)) u_wptr (
        .clk        (clk),
        .rst        (rst),
        .buf_rst    (buf_rst),
        .wr_stb     (wr_stb),
        .wrap_clr   (wrap_clr),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .addr       (addr),
        .wrap       (wrap)
    );

    ptr_snap_capture #(.PAD_W(PAD_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .live   (live),
        .held   (held)
    );

    ptr_snap_rdmux #(.PAD_W(PAD_W), .SEL_W(2)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .live_lo (live[7:0]),
        .held    (held),
        .rd_data (rd_data)
    );

    AST_HI_RSV_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'(NB - 1)) |=> (rd_data & HI_MASK) == 8'h00); // R8
    AST_LO_LIVE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd0) |=> rd_data == $past(addr[7:0])); // R7

endmodule

// File: tb/ptr_snap_reader_tb.sv
module ptr_snap_reader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        buf_rst = 1'b0;
    logic        wr_stb = 1'b0;
    logic        wrap_clr = 1'b0;
    logic [18:0] start_addr = '0;
    logic [18:0] end_addr = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    ptr_snap_reader u_dut (
        .clk(clk), .rst(rst), .buf_rst(buf_rst), .wr_stb(wr_stb),
        .wrap_clr(wrap_clr), .start_addr(start_addr), .end_addr(end_addr),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        rd_en = 1'b1; rd_sel = sel;
        tick();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            wr_stb = 1'b1;
            tick();
        end
        wr_stb = 1'b0;
    endtask

    task automatic setup(input logic [18:0] s, input logic [18:0] e);
        start_addr = s; end_addr = e; buf_rst = 1'b1;
        tick();
        buf_rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        rd(2'd0, d); chk("R1 low", d, 8'h00);
        rd(2'd1, d); chk("R1 mid", d, 8'h00);
        rd(2'd2, d); chk("R1 top", d, 8'h00);
    endtask

    task automatic t_advance();
        logic [7:0] d;
        setup(19'h123F0, 19'h12410);
        strobe(5);
        rd(2'd0, d); chk("R3 R7 low after 5 steps", d, 8'hF5);
        rd(2'd1, d); chk("R8 mid", d, 8'h23);
        rd(2'd2, d); chk("R8 top", d, 8'h01);
        strobe(12);
        rd(2'd0, d); chk("R3 crosses byte", d, 8'h01);
        rd(2'd1, d); chk("R3 mid carry", d, 8'h24);
    endtask

    task automatic t_torn();
        logic [7:0] d;
        setup(19'h1FFFE, 19'h20005);
        rd(2'd0, d); chk("R7 low snapshot", d, 8'hFE);
        strobe(3);
        rd(2'd1, d); chk("R8 mid held", d, 8'hFF);
        rd(2'd2, d); chk("R8 top held", d, 8'h01);
        rd(2'd0, d); chk("R7 new low", d, 8'h01);
        rd(2'd1, d); chk("R8 new mid", d, 8'h00);
        rd(2'd2, d); chk("R8 new top", d, 8'h02);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        setup(19'h00100, 19'h00103);
        strobe(3);
        rd(2'd0, d); rd(2'd2, d); chk("R4 no wrap yet", d, 8'h00);
        strobe(1);
        rd(2'd0, d); chk("R4 reload start", d, 8'h00);
        rd(2'd1, d); chk("R4 mid", d, 8'h01);
        rd(2'd2, d); chk("R4 wrap flag bit3", d, 8'h08);
        strobe(2);
        rd(2'd0, d); chk("R5 low", d, 8'h02);
        rd(2'd2, d); chk("R5 flag sticky", d, 8'h08);
        wrap_clr = 1'b1; tick(); wrap_clr = 1'b0;
        rd(2'd0, d); rd(2'd2, d); chk("R5 clear", d, 8'h00);
        strobe(1);
        wr_stb = 1'b1; wrap_clr = 1'b1; tick();
        wr_stb = 1'b0; wrap_clr = 1'b0;
        rd(2'd0, d); chk("R5 wrapped low", d, 8'h00);
        rd(2'd2, d); chk("R5 set wins over clear", d, 8'h08);
    endtask

    task automatic t_bufrst();
        logic [7:0] d;
        start_addr = 19'h00100;
        buf_rst = 1'b1; wr_stb = 1'b1; tick();
        buf_rst = 1'b0; wr_stb = 1'b0;
        rd(2'd0, d); chk("R6 start over strobe", d, 8'h00);
        rd(2'd1, d); chk("R6 mid", d, 8'h01);
        rd(2'd2, d); chk("R6 flag cleared", d, 8'h00);
    endtask

    task automatic t_rsv_hold();
        logic [7:0] d;
        setup(19'h7FFFF, 19'h7FFFF);
        strobe(1);
        rd(2'd0, d); chk("R7 low all ones", d, 8'hFF);
        rd(2'd2, d); chk("R8 top nibble zero", d, 8'h0F);
        rd(2'd3, d); chk("R9 reserved code", d, 8'h00);
        rd(2'd1, d);
        strobe(2);
        repeat (3) tick();
        chk("R2 hold without read", rd_data, 8'hFF);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_advance();
        t_torn();
        t_wrap();
        t_bufrst();
        t_rsv_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule